// File: doc/BRIEF.md
# SMBus Master Byte Sequencer

This block is the byte-level master engine of a two-wire bus controller. Software acts on it through single-cycle strobes. It can request a start or a stop, write or read the data byte, and clear status flags. The engine turns these strobes into operations on an abstract byte bus. Those operations are: open a transfer (7-bit target plus direction), send a byte, receive a byte, and end the transfer. The bus returns an acknowledge in the same cycle as the request. A set of status flags reports master mode, transfer direction, data-ready, negative acknowledge, bus error, start stall, busy, bus held, end of busy and receive-FIFO ready.

A stop is not always carried out when it is requested. When the stop arrives during a receive, it waits for the next data read, so software can collect the last byte. When it arrives after a refused byte, it waits until software clears the negative-acknowledge flag. A start is accepted while a transfer is still open, which gives a repeated start.

In FIFO mode, a receive fetches bytes one per cycle into a small buffer until a threshold is reached. Data reads then pop that buffer.

Top module: `smbus_master_seq`

## Requirements
- R1: After reset all status flags are 0, the data byte reads 0, the FIFO count is 0 and no bus strobe is active.
- R2: A start strobe succeeds when `bus_free_i` is 1 or the sequencer is not idle (repeated start). On success it sets master, tx_dir, data_rdy and busy, and in FIFO mode also fifo_rdy. On failure it clears master and busy and sets bus_err. In both cases it sets bus_held and returns the sequencer to idle.
- R3: A data write in master mode while idle opens a transfer: `bus_start_o` pulses in that cycle with target = wdata[7:1] and read = wdata[0] (1 means read). While sending, a data write pulses `bus_send_o` with the byte. In any other state, or outside master mode, a data write causes no bus strobe and changes no flag.
- R4: A refused address sets nack, clears data_rdy, sets tx_dir to the inverse of wdata[0] and enters the negative-ack state. An accepted address clears nack and enters receiving (tx_dir 0) for a read or sending (tx_dir 1) for a write.
- R5: After an accepted address with stall_en_i set, stall and data_rdy are set and nothing is received. Otherwise a read starts a reception, and a write sets data_rdy (and fifo_rdy in FIFO mode). A single-mode reception pulses `bus_recv_o` in the same cycle, shows the byte on `rdata_o` from the next cycle and sets data_rdy.
- R6: Clearing the stall flag while receiving starts a reception.
- R7: A stop strobe in master mode moves receiving (or stopping-after-receive) to stopping-after-receive. It moves negative-ack to stopping-after-negative-ack. Neither of these pulses `bus_end_o`. In any other state the stop is executed at once.
- R8: Executing a stop pulses `bus_end_o`, clears master and busy, sets end_busy and returns to idle. At most one of start, send and end strobes is active per cycle.
- R9: A data read in stopping-after-receive executes the stop. In FIFO mode it does so only when the count is 1 or less, and it pops a byte whenever the count is non-zero. `rdata_o` shows the byte held before the read; a pop replaces it with the FIFO head.
- R10: A data read while receiving fetches the next byte in single mode. In FIFO mode it pops the head, or starts a refill when the FIFO is empty.
- R11: Clearing nack in the stopping-after-negative-ack state executes the stop.
- R12: A refused data byte clears data_rdy, sets nack and enters negative-ack. An accepted byte sets data_rdy (and fifo_rdy in FIFO mode).
- R13: A FIFO reception fetches min(rx_thr_i, depth) minus the current count bytes, one per cycle, starting the cycle after the request. data_rdy is cleared at the request and set one cycle after the last fetch.
- R14: The clear strobes for bus_err, bus_held, end_busy and fifo_rdy each clear their flag. A flag being set in the same cycle wins over its clear. When several commands arrive together, only the first in the order start, stop, write, read, nack-clear, stall-clear is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request strobe |
| stop_i | input | 1 | Stop request strobe |
| wr_i | input | 1 | Data byte write strobe |
| wdata_i | input | 8 | Data byte written |
| rd_i | input | 1 | Data byte read strobe |
| rdata_o | output | 8 | Current data byte |
| nack_clr_i | input | 1 | Clear negative acknowledge |
| stall_clr_i | input | 1 | Clear start stall |
| err_clr_i | input | 1 | Clear bus error |
| held_clr_i | input | 1 | Clear bus held |
| eob_clr_i | input | 1 | Clear end of busy |
| rdy_clr_i | input | 1 | Clear FIFO ready |
| stall_en_i | input | 1 | Stall after an accepted address |
| fifo_mode_i | input | 1 | Receive through the FIFO |
| rx_thr_i | input | CNT_W | FIFO receive threshold |
| bus_free_i | input | 1 | Bus is not occupied |
| bus_start_o | output | 1 | Open transfer strobe |
| bus_addr_o | output | 7 | Target address |
| bus_rd_o | output | 1 | Transfer direction, 1 is read |
| bus_send_o | output | 1 | Send byte strobe |
| bus_wdata_o | output | 8 | Byte to send |
| bus_ack_i | input | 1 | Acknowledge for open or send |
| bus_recv_o | output | 1 | Receive byte strobe |
| bus_rdata_i | input | 8 | Received byte, valid with the strobe |
| bus_end_o | output | 1 | End transfer strobe |
| master_o | output | 1 | Master mode |
| tx_dir_o | output | 1 | Transmit direction |
| data_rdy_o | output | 1 | Data register ready |
| nack_o | output | 1 | Negative acknowledge seen |
| bus_err_o | output | 1 | Start refused |
| stall_o | output | 1 | Stalled after address |
| busy_o | output | 1 | Transfer in progress |
| bus_held_o | output | 1 | Bus held since a start |
| end_busy_o | output | 1 | A stop has executed |
| fifo_rdy_o | output | 1 | FIFO ready |
| rx_cnt_o | output | CNT_W | Bytes in the receive FIFO |

## Verification
Some rules hold on every cycle and are checked by the bound assertions. A start on a free bus raises master, busy and bus-held. A refused start from idle raises the bus error. Every end strobe leaves the engine idle with end-of-busy set. A refused address lands in the negative-ack state with data-ready low. A stop during a receive never ends the bus at once, and the start, send and end strobes never coincide. The scenarios are needed for the behaviour that spans several commands. These are the deferred stops completed by a later read or a nack clear, the stall release, repeated start, the order and content of bus operations, and the FIFO fill with its pop-and-stop rule at the final count.

// File: rtl/smseq_pkg.sv
package smseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_RECV, S_NACK, S_STOP_RX, S_STOP_NK
  } state_e;

  typedef struct packed {
    logic master;
    logic tx_dir;
    logic data_rdy;
    logic nack;
    logic bus_err;
    logic stall;
    logic busy;
    logic bus_held;
    logic end_busy;
    logic fifo_rdy;
  } flags_t;
endpackage

// File: rtl/smseq_rx_fifo.sv
module smseq_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [7:0]       wdata_i,
  input  logic             pop_i,
  output logic [7:0]       head_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assign head_o = mem[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/smseq_rx_fill.sv
module smseq_rx_fill #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             recv_o,
  output logic             done_o
);
  logic [CNT_W-1:0] target, need, rem_q;
  logic             active_q, done_q;

  assign target = (thr_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : thr_i;
  assign need   = (target > cnt_i) ? target - cnt_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (start_i && need == '0) || (!start_i && active_q && rem_q == CNT_W'(1));
      if (start_i) begin
        active_q <= (need != '0);
        rem_q    <= need;
      end else if (active_q) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) active_q <= 1'b0;
      end
    end
  end

  assign recv_o = active_q;
  assign done_o = done_q;
endmodule

// File: rtl/smseq_ctrl.sv
module smseq_ctrl
  import smseq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_i,
  input  logic             nack_clr_i,
  input  logic             stall_clr_i,
  input  logic             err_clr_i,
  input  logic             held_clr_i,
  input  logic             eob_clr_i,
  input  logic             rdy_clr_i,
  input  logic             stall_en_i,
  input  logic             fifo_mode_i,
  input  logic             bus_free_i,
  input  logic             bus_ack_i,
  input  logic [7:0]       bus_rdata_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [7:0]       fifo_head_i,
  input  logic             fill_done_i,
  output logic             bus_start_o,
  output logic             bus_send_o,
  output logic             bus_recv_o,
  output logic             bus_end_o,
  output logic             fill_start_o,
  output logic             pop_o,
  output logic [7:0]       rdata_o,
  output flags_t           flags_o,
  output state_e           state_o
);
  flags_t     f_q, f_d;
  state_e     st_q, st_d;
  logic [7:0] sda_q, sda_d;
  logic       do_stop, do_rx;

  always_comb begin
    f_d = f_q;  st_d = st_q;  sda_d = sda_q;
    bus_start_o = 1'b0;  bus_send_o = 1'b0;  bus_recv_o = 1'b0;
    bus_end_o = 1'b0;  fill_start_o = 1'b0;  pop_o = 1'b0;
    do_stop = 1'b0;  do_rx = 1'b0;

    if (err_clr_i)   f_d.bus_err  = 1'b0;
    if (held_clr_i)  f_d.bus_held = 1'b0;
    if (eob_clr_i)   f_d.end_busy = 1'b0;
    if (rdy_clr_i)   f_d.fifo_rdy = 1'b0;
    if (fill_done_i) f_d.data_rdy = 1'b1;

    if (start_i) begin
      if (bus_free_i || st_q != S_IDLE) begin
        f_d.master = 1'b1;  f_d.tx_dir = 1'b1;  f_d.data_rdy = 1'b1;  f_d.busy = 1'b1;
        if (fifo_mode_i) f_d.fifo_rdy = 1'b1;
      end else begin
        f_d.master = 1'b0;  f_d.busy = 1'b0;  f_d.bus_err = 1'b1;
      end
      f_d.bus_held = 1'b1;
      st_d = S_IDLE;
    end else if (stop_i) begin
      if (f_q.master) begin
        unique case (st_q)
          S_RECV, S_STOP_RX: st_d = S_STOP_RX;
          S_NACK:            st_d = S_STOP_NK;
          default:           do_stop = 1'b1;
        endcase
      end
    end else if (wr_i) begin
      if (f_q.master && st_q == S_IDLE) begin
        bus_start_o = 1'b1;
        if (!bus_ack_i) begin
          f_d.tx_dir = !wdata_i[0];  f_d.nack = 1'b1;  f_d.data_rdy = 1'b0;
          st_d = S_NACK;
        end else begin
          f_d.nack   = 1'b0;
          f_d.tx_dir = !wdata_i[0];
          st_d = wdata_i[0] ? S_RECV : S_SEND;
          if (stall_en_i) begin
            f_d.stall = 1'b1;  f_d.data_rdy = 1'b1;
          end else if (wdata_i[0]) begin
            do_rx = 1'b1;
          end else begin
            f_d.data_rdy = 1'b1;
            if (fifo_mode_i) f_d.fifo_rdy = 1'b1;
          end
        end
      end else if (f_q.master && st_q == S_SEND) begin
        bus_send_o = 1'b1;
        if (!bus_ack_i) begin
          f_d.data_rdy = 1'b0;  f_d.nack = 1'b1;  st_d = S_NACK;
        end else begin
          f_d.data_rdy = 1'b1;
          if (fifo_mode_i) f_d.fifo_rdy = 1'b1;
        end
      end
    end else if (rd_i) begin
      if (st_q == S_STOP_RX) begin
        if (fifo_mode_i) begin
          if (fifo_cnt_i <= CNT_W'(1)) do_stop = 1'b1;
          if (fifo_cnt_i != '0) pop_o = 1'b1;
        end else begin
          do_stop = 1'b1;
        end
      end else if (st_q == S_RECV) begin
        if (fifo_mode_i && fifo_cnt_i != '0) pop_o = 1'b1;
        else do_rx = 1'b1;
      end
    end else if (nack_clr_i) begin
      f_d.nack = 1'b0;
      if (st_q == S_STOP_NK) do_stop = 1'b1;
    end else if (stall_clr_i) begin
      f_d.stall = 1'b0;
      if (st_q == S_RECV) do_rx = 1'b1;
    end

    if (do_rx) begin
      if (fifo_mode_i) begin
        fill_start_o = 1'b1;  f_d.data_rdy = 1'b0;
      end else begin
        bus_recv_o = 1'b1;  sda_d = bus_rdata_i;  f_d.data_rdy = 1'b1;
      end
    end
    if (pop_o) sda_d = fifo_head_i;
    if (do_stop) begin
      bus_end_o = 1'b1;
      f_d.master = 1'b0;  f_d.busy = 1'b0;  f_d.end_busy = 1'b1;
      st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q   <= '0;
      st_q  <= S_IDLE;
      sda_q <= '0;
    end else begin
      f_q   <= f_d;
      st_q  <= st_d;
      sda_q <= sda_d;
    end
  end

  assign rdata_o = sda_q;
  assign flags_o = f_q;
  assign state_o = st_q;
endmodule

// File: rtl/smbus_master_seq.sv
module smbus_master_seq
  import smseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  input  logic             nack_clr_i,
  input  logic             stall_clr_i,
  input  logic             err_clr_i,
  input  logic             held_clr_i,
  input  logic             eob_clr_i,
  input  logic             rdy_clr_i,
  input  logic             stall_en_i,
  input  logic             fifo_mode_i,
  input  logic [CNT_W-1:0] rx_thr_i,
  input  logic             bus_free_i,
  output logic             bus_start_o,
  output logic [6:0]       bus_addr_o,
  output logic             bus_rd_o,
  output logic             bus_send_o,
  output logic [7:0]       bus_wdata_o,
  input  logic             bus_ack_i,
  output logic             bus_recv_o,
  input  logic [7:0]       bus_rdata_i,
  output logic             bus_end_o,
  output logic             master_o,
  output logic             tx_dir_o,
  output logic             data_rdy_o,
  output logic             nack_o,
  output logic             bus_err_o,
  output logic             stall_o,
  output logic             busy_o,
  output logic             bus_held_o,
  output logic             end_busy_o,
  output logic             fifo_rdy_o,
  output logic [CNT_W-1:0] rx_cnt_o
);
  flags_t           flags;
  state_e           st;
  logic             ctrl_recv, fill_recv, fill_start, fill_done, pop;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_cnt;

  smseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .wr_i, .wdata_i, .rd_i,
    .nack_clr_i, .stall_clr_i, .err_clr_i, .held_clr_i, .eob_clr_i, .rdy_clr_i,
    .stall_en_i, .fifo_mode_i, .bus_free_i, .bus_ack_i, .bus_rdata_i,
    .fifo_cnt_i(fifo_cnt), .fifo_head_i(fifo_head), .fill_done_i(fill_done),
    .bus_start_o, .bus_send_o, .bus_recv_o(ctrl_recv), .bus_end_o,
    .fill_start_o(fill_start), .pop_o(pop), .rdata_o,
    .flags_o(flags), .state_o(st)
  );

  smseq_rx_fill #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fill (
    .clk_i, .rst_ni, .start_i(fill_start), .thr_i(rx_thr_i), .cnt_i(fifo_cnt),
    .recv_o(fill_recv), .done_o(fill_done)
  );

  smseq_rx_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni, .push_i(fill_recv), .wdata_i(bus_rdata_i), .pop_i(pop),
    .head_o(fifo_head), .cnt_o(fifo_cnt)
  );

  assign bus_recv_o  = ctrl_recv | fill_recv;
  assign bus_addr_o  = wdata_i[7:1];
  assign bus_rd_o    = wdata_i[0];
  assign bus_wdata_o = wdata_i;
  assign rx_cnt_o    = fifo_cnt;

  assign master_o   = flags.master;
  assign tx_dir_o   = flags.tx_dir;
  assign data_rdy_o = flags.data_rdy;
  assign nack_o     = flags.nack;
  assign bus_err_o  = flags.bus_err;
  assign stall_o    = flags.stall;
  assign busy_o     = flags.busy;
  assign bus_held_o = flags.bus_held;
  assign end_busy_o = flags.end_busy;
  assign fifo_rdy_o = flags.fifo_rdy;
endmodule

// File: rtl/smseq_checker.sv
module smseq_checker
  import smseq_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   start_i,
  input logic   stop_i,
  input logic   wr_i,
  input logic   bus_free_i,
  input logic   bus_ack_i,
  input logic   bus_start_o,
  input logic   bus_send_o,
  input logic   bus_end_o,
  input logic   master_o,
  input logic   busy_o,
  input logic   bus_held_o,
  input logic   data_rdy_o,
  input logic   bus_err_o,
  input logic   nack_o,
  input logic   end_busy_o,
  input state_e st
);
  p_start_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && bus_free_i |=> master_o && busy_o && bus_held_o && data_rdy_o);

  p_start_fail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !bus_free_i && st == S_IDLE |=> bus_err_o && !master_o && !busy_o && bus_held_o);

  p_wr_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !start_i && !stop_i && !(master_o && (st == S_IDLE || st == S_SEND))
      |-> !bus_start_o && !bus_send_o);

  p_addr_nack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o && !bus_ack_i |=> nack_o && !data_rdy_o && st == S_NACK);

  p_stop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i && master_o && st == S_RECV |-> !bus_end_o);

  p_stop_defer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i && master_o && st == S_RECV |=> st == S_STOP_RX);

  p_stop_effect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_end_o |=> !master_o && !busy_o && end_busy_o && st == S_IDLE);

  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_start_o, bus_send_o, bus_end_o}));
endmodule

bind smbus_master_seq smseq_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i), .wr_i(wr_i),
  .bus_free_i(bus_free_i), .bus_ack_i(bus_ack_i), .bus_start_o(bus_start_o),
  .bus_send_o(bus_send_o), .bus_end_o(bus_end_o), .master_o(master_o),
  .busy_o(busy_o), .bus_held_o(bus_held_o), .data_rdy_o(data_rdy_o),
  .bus_err_o(bus_err_o), .nack_o(nack_o), .end_busy_o(end_busy_o), .st(st)
);

// File: tb/smbus_master_seq_tb.sv
module smbus_master_seq_tb_top;
  localparam int CNT_W = 5;
  localparam int C_START = 0, C_STOP = 1, C_WR = 2, C_RD = 3, C_NCLR = 4,
                 C_SCLR = 5, C_ECLR = 6, C_HCLR = 7, C_BCLR = 8, C_RCLR = 9;
  localparam int K_START = 0, K_SEND = 1, K_RECV = 2, K_END = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, wr_i = 0, rd_i = 0;
  logic [7:0] wdata_i = '0;
  logic nack_clr_i = 0, stall_clr_i = 0, err_clr_i = 0, held_clr_i = 0, eob_clr_i = 0, rdy_clr_i = 0;
  logic stall_en_i = 0, fifo_mode_i = 0, bus_free_i = 1, bus_ack_i = 1;
  logic [CNT_W-1:0] rx_thr_i = '0;
  logic [7:0] rx_byte = 8'h80;
  logic [7:0] rdata_o, bus_wdata_o;
  logic [6:0] bus_addr_o;
  logic bus_start_o, bus_rd_o, bus_send_o, bus_recv_o, bus_end_o;
  logic master_o, tx_dir_o, data_rdy_o, nack_o, bus_err_o, stall_o, busy_o, bus_held_o, end_busy_o, fifo_rdy_o;
  logic [CNT_W-1:0] rx_cnt_o;
  wire [9:0] fl = {master_o, tx_dir_o, data_rdy_o, nack_o, bus_err_o, stall_o,
                   busy_o, bus_held_o, end_busy_o, fifo_rdy_o};

  int tests = 0, fails = 0;
  logic [9:0] evq[$];
  logic [7:0] nxt_rx = 8'h80;

  always #10 clk_i = ~clk_i;

  smbus_master_seq dut_i (
    .clk_i, .rst_ni, .start_i, .stop_i, .wr_i, .wdata_i, .rd_i, .rdata_o,
    .nack_clr_i, .stall_clr_i, .err_clr_i, .held_clr_i, .eob_clr_i, .rdy_clr_i,
    .stall_en_i, .fifo_mode_i, .rx_thr_i, .bus_free_i, .bus_start_o, .bus_addr_o,
    .bus_rd_o, .bus_send_o, .bus_wdata_o, .bus_ack_i, .bus_recv_o,
    .bus_rdata_i(rx_byte), .bus_end_o, .master_o, .tx_dir_o, .data_rdy_o, .nack_o,
    .bus_err_o, .stall_o, .busy_o, .bus_held_o, .end_busy_o, .fifo_rdy_o, .rx_cnt_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input int kind, input logic [7:0] d);
    evq.push_back({kind[1:0], d});
  endtask

  task automatic ev_rx();
    ev(K_RECV, nxt_rx);
    nxt_rx = nxt_rx + 8'd1;
  endtask

  task automatic cmd(input int c, input logic [7:0] d);
    wdata_i = d;
    case (c)
      C_START: start_i = 1;     C_STOP: stop_i = 1;       C_WR: wr_i = 1;
      C_RD:    rd_i = 1;        C_NCLR: nack_clr_i = 1;   C_SCLR: stall_clr_i = 1;
      C_ECLR:  err_clr_i = 1;   C_HCLR: held_clr_i = 1;   C_BCLR: eob_clr_i = 1;
      default: rdy_clr_i = 1;
    endcase
    @(negedge clk_i);
    {start_i, stop_i, wr_i, rd_i, nack_clr_i, stall_clr_i} = '0;
    {err_clr_i, held_clr_i, eob_clr_i, rdy_clr_i} = '0;
  endtask

  // scoreboard monitor: strobes sampled late in the low phase
  task automatic mon_cmp(input int kind, input logic [7:0] d);
    logic [9:0] got;
    got = {kind[1:0], d};
    tests++;
    if (evq.size() == 0) begin
      fails++;
      $display("FAIL R3/R8 bus event: actual 0x%0h expected none", got);
    end else begin
      logic [9:0] e;
      e = evq.pop_front();
      if (e != got) begin
        fails++;
        $display("FAIL R3/R5/R8 bus event: actual 0x%0h expected 0x%0h", got, e);
      end
    end
  endtask

  always begin
    @(negedge clk_i);
    #5;
    if (rst_ni) begin
      if (bus_start_o) mon_cmp(K_START, {bus_addr_o, bus_rd_o});
      if (bus_send_o)  mon_cmp(K_SEND, bus_wdata_o);
      if (bus_recv_o)  mon_cmp(K_RECV, rx_byte);
      if (bus_end_o)   mon_cmp(K_END, 8'h00);
      if (bus_recv_o) begin
        @(posedge clk_i);
        #1 rx_byte = rx_byte + 8'd1;
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 flags", fl, 10'h000);
    chk("R1 rdata", rdata_o, 0);
    chk("R1 count", rx_cnt_o, 0);

    // write transfer
    cmd(C_START, 0);            chk("R2 start ok", fl, 10'h38C);
    ev(K_START, 8'hA4);
    cmd(C_WR, 8'hA4);           chk("R3 R4 addr write ack", fl, 10'h38C);
    ev(K_SEND, 8'h3C);
    cmd(C_WR, 8'h3C);           chk("R12 send ack", fl, 10'h38C);
    bus_ack_i = 0;
    ev(K_SEND, 8'h55);
    cmd(C_WR, 8'h55);           chk("R12 send nack", fl, 10'h34C);
    cmd(C_WR, 8'h77);           chk("R3 write ignored in nack", fl, 10'h34C);
    chk("R3 no event queued", evq.size(), 0);
    cmd(C_STOP, 0);             chk("R7 stop deferred on nack", fl, 10'h34C);
    ev(K_END, 0);
    cmd(C_NCLR, 0);             chk("R11 nack clear stops", fl, 10'h106);
    cmd(C_BCLR, 0);  cmd(C_HCLR, 0);
    chk("R14 clears", fl, 10'h100);
    bus_ack_i = 1;

    // refused start
    bus_free_i = 0;
    cmd(C_START, 0);            chk("R2 start refused", fl, 10'h124);
    cmd(C_WR, 8'hA4);           chk("R3 write ignored outside master", fl, 10'h124);
    cmd(C_ECLR, 0);             chk("R14 err clear", fl, 10'h104);
    cmd(C_HCLR, 0);
    bus_free_i = 1;

    // single-byte read with deferred stop
    cmd(C_START, 0);
    ev(K_START, 8'hA5);  ev_rx();
    cmd(C_WR, 8'hA5);           chk("R5 read addr flags", fl, 10'h28C);
    chk("R5 first byte", rdata_o, 8'h80);
    ev_rx();
    cmd(C_RD, 0);               chk("R10 next byte", rdata_o, 8'h81);
    cmd(C_STOP, 0);             chk("R7 stop deferred on receive", fl, 10'h28C);
    ev(K_END, 0);
    cmd(C_RD, 0);               chk("R9 read executes stop", fl, 10'h086);
    chk("R9 rdata kept", rdata_o, 8'h81);
    cmd(C_BCLR, 0);  cmd(C_HCLR, 0);

    // stall after address
    stall_en_i = 1;
    cmd(C_START, 0);
    ev(K_START, 8'hA5);
    cmd(C_WR, 8'hA5);           chk("R5 stall set", fl, 10'h29C);
    ev_rx();
    cmd(C_SCLR, 0);             chk("R6 stall clear receives", fl, 10'h28C);
    chk("R6 byte", rdata_o, 8'h82);
    cmd(C_STOP, 0);
    ev(K_END, 0);
    cmd(C_RD, 0);               chk("R8 stop flags", fl, 10'h086);
    cmd(C_BCLR, 0);  cmd(C_HCLR, 0);
    stall_en_i = 0;

    // read address refused
    cmd(C_START, 0);
    bus_ack_i = 0;
    ev(K_START, 8'hA5);
    cmd(C_WR, 8'hA5);           chk("R4 read addr nack", fl, 10'h24C);
    cmd(C_STOP, 0);
    ev(K_END, 0);
    cmd(C_NCLR, 0);             chk("R11 stop after nack", fl, 10'h006);
    cmd(C_BCLR, 0);  cmd(C_HCLR, 0);
    bus_ack_i = 1;

    // repeated start then immediate stop while sending
    cmd(C_START, 0);
    ev(K_START, 8'hA4);
    cmd(C_WR, 8'hA4);
    bus_free_i = 0;
    cmd(C_START, 0);            chk("R2 repeated start", fl, 10'h38C);
    ev(K_START, 8'hB0);
    cmd(C_WR, 8'hB0);
    ev(K_END, 0);
    cmd(C_STOP, 0);             chk("R7 R8 immediate stop", fl, 10'h186);
    bus_free_i = 1;
    cmd(C_BCLR, 0);  cmd(C_HCLR, 0);

    // FIFO reception
    fifo_mode_i = 1;  rx_thr_i = CNT_W'(3);
    cmd(C_START, 0);            chk("R2 fifo ready", fl, 10'h38D);
    ev(K_START, 8'hA5);  ev_rx();  ev_rx();  ev_rx();
    cmd(C_WR, 8'hA5);           chk("R13 fill request clears rdy", fl, 10'h20D);
    repeat (6) @(negedge clk_i);
    chk("R13 fill count", rx_cnt_o, 3);
    chk("R13 rdy after fill", fl, 10'h28D);
    cmd(C_RD, 0);               chk("R10 pop head", rdata_o, 8'h83);
    cmd(C_STOP, 0);
    cmd(C_RD, 0);               chk("R9 pop without stop", rdata_o, 8'h84);
    chk("R9 still master", master_o, 1);
    ev(K_END, 0);
    cmd(C_RD, 0);               chk("R9 last pop stops", fl, 10'h087);
    chk("R9 last byte", rdata_o, 8'h85);
    chk("R9 count empty", rx_cnt_o, 0);
    cmd(C_RCLR, 0);             chk("R14 fifo ready clear", fl, 10'h086);

    repeat (3) @(negedge clk_i);
    chk("R8 all events seen", evq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule